// File: doc/BRIEF.md
# SPI FIFO Pair with Sticky Error Status

This block holds the word storage between a register bus and an SPI shift engine. It has two FIFOs of 32-bit words. Software pushes words into the transmit FIFO and the shift engine pops them. The shift engine pushes received words into the receive FIFO and software pops them. Each side has its own data port. A single 32-bit status word reports the live fill state of both FIFOs, latched error flags, a summary error bit, per-FIFO flush controls and two mirrored link conditions.

Software polls the status word. After a transfer it writes the value it read back to the status port, which acknowledges every latched error in one write. To discard stale data before a transfer, software writes the flush bits and polls until they read zero. The FIFO depth must be a power of two, at least 2.

Status bit map (bit: meaning):
- 0: receive empty
- 1: receive full
- 2: transmit empty
- 3: transmit full
- 4: receive underrun
- 5: receive overflow
- 6: transmit underrun
- 7: transmit overflow
- 8: error summary
- 14: transmit flush
- 15: receive flush
- 30: frame end
- 31: chip select idle

Top module: `spi_fifo_pair`

## Requirements
- R1: After reset the status word reads 0x0000_0005: both FIFOs are empty, and no flag or flush bit is set while frame_end_i and cs_idle_i are low.
- R2: Each FIFO holds DEPTH (default 8) words and returns them in push order. Its full bit (1 for receive, 3 for transmit) is 1 exactly when it holds DEPTH words. Its empty bit (0 for receive, 2 for transmit) is 1 exactly when it holds none.
- R3: A push into a full FIFO is discarded, with or without a pop in the same cycle. It sets the overflow flag of that FIFO (bit 5 for receive, bit 7 for transmit), and the stored contents are unchanged.
- R4: A software pop from the empty receive FIFO returns zero, sets receive underrun (bit 4) and moves no pointer.
- R5: An engine pop from the empty transmit FIFO returns zero and sets transmit underrun (bit 6). An engine push into the full receive FIFO sets receive overflow (bit 5).
- R6: Bit 8 reads 1 whenever any of bits 4 to 7 reads 1, and reads 0 otherwise.
- R7: A status write clears each of bits 4 to 7 that is written as 1 and leaves the others unchanged. Writing back a value that was read clears every flag it showed. If a flag is set and cleared in the same cycle, the set wins.
- R8: Writing 1 to bit 15 flushes the receive FIFO and writing 1 to bit 14 flushes the transmit FIFO. The bit reads 1 in the cycle after the write. One cycle later the FIFO is empty and the bit reads 0. Bits 4 to 7 are not changed by a flush.
- R9: Bits 0 to 3 are not affected by status writes.
- R10: Bit 30 mirrors frame_end_i, bit 31 mirrors cs_idle_i, and all unassigned bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_push_i | input | 1 | Software push into transmit FIFO |
| sw_wdata_i | input | 32 | Word to push into transmit FIFO |
| sw_pop_i | input | 1 | Software pop from receive FIFO |
| sw_rdata_o | output | 32 | Head of receive FIFO, zero when empty |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | 32 | Status write data |
| sts_rdata_o | output | 32 | Status word |
| eng_pop_i | input | 1 | Engine pop from transmit FIFO |
| eng_rdata_o | output | 32 | Head of transmit FIFO, zero when empty |
| eng_push_i | input | 1 | Engine push into receive FIFO |
| eng_wdata_i | input | 32 | Word to push into receive FIFO |
| frame_end_i | input | 1 | Frame end condition, mirrored to status |
| cs_idle_i | input | 1 | Chip select idle condition, mirrored to status |

## Verification
The bench pushes a ninth word into a full FIFO. A design that wraps its pointers would overwrite the oldest word, or would report empty after the ninth push. It pops from empty FIFOs. A design that moves the read pointer there would later return stale data, and one that does not return zero would leak old words. The bench writes zero, then single bits, then the value read back to the status word. This catches clearing on any write, clearing of the wrong flag, or a summary bit that does not follow the flags. It flushes with flags already set, which catches a flush that also wipes the error history or never clears its own bit. It writes ones over the live fill bits to confirm they cannot be forced.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int STS_RX_EMPTY  = 0;
  localparam int STS_RX_FULL   = 1;
  localparam int STS_TX_EMPTY  = 2;
  localparam int STS_TX_FULL   = 3;
  localparam int STS_RX_UNR    = 4;
  localparam int STS_RX_OVF    = 5;
  localparam int STS_TX_UNR    = 6;
  localparam int STS_TX_OVF    = 7;
  localparam int STS_ERR       = 8;
  localparam int STS_TX_FLUSH  = 14;
  localparam int STS_RX_FLUSH  = 15;
  localparam int STS_FRAME_END = 30;
  localparam int STS_CS_IDLE   = 31;
  localparam int NUM_STICKY    = 4;
  localparam int STICKY_LSB    = STS_RX_UNR;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o,
  output logic         ovf_o,
  output logic         unr_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW:0]  wr_q, rd_q;
  logic         do_push, do_pop;

  assign empty_o = (wr_q == rd_q);
  assign full_o  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign ovf_o   = push_i && full_o && !flush_i;
  assign unr_o   = pop_i && empty_o && !flush_i;
  assign rdata_o = empty_o ? '0 : mem_q[rd_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else if (flush_i) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q[AW-1:0]] <= wdata_i;
  end

  // R3
  ovf_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> (full_o && $stable(wr_q)));

  // R4
  unr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i && !flush_i) |=> (empty_o && $stable(rd_q)));

  // R8
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/spi_sticky_w1c.sv
module spi_sticky_w1c #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_o[i] <= 1'b0;
      else if (set_i[i])  q_o[i] <= 1'b1;
      else if (clr_i[i])  q_o[i] <= 1'b0;
    end

    // R7
    w1c_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> q_o[i]);

    // R7
    w1c_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !q_o[i]);

    // R7
    w1c_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[i] && !set_i[i]) |=> $stable(q_o[i]));
  end
endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
  import spi_fifo_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sw_push_i,
  input  logic [31:0]  sw_wdata_i,
  input  logic         sw_pop_i,
  output logic [31:0]  sw_rdata_o,
  input  logic         sts_wr_i,
  input  logic [31:0]  sts_wdata_i,
  output logic [31:0]  sts_rdata_o,
  input  logic         eng_pop_i,
  output logic [31:0]  eng_rdata_o,
  input  logic         eng_push_i,
  input  logic [31:0]  eng_wdata_i,
  input  logic         frame_end_i,
  input  logic         cs_idle_i
);
  logic tx_flush_q, rx_flush_q;
  logic tx_full, tx_empty, tx_ovf, tx_unr;
  logic rx_full, rx_empty, rx_ovf, rx_unr;
  logic [NUM_STICKY-1:0] sticky_set, sticky_clr, sticky_q;
  logic unused_wdata;

  assign unused_wdata = ^{sts_wdata_i[31:16], sts_wdata_i[13:8], sts_wdata_i[3:0]};

  spi_word_fifo #(.W(W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (tx_flush_q),
    .push_i  (sw_push_i),
    .wdata_i (sw_wdata_i),
    .pop_i   (eng_pop_i),
    .rdata_o (eng_rdata_o),
    .full_o  (tx_full),
    .empty_o (tx_empty),
    .ovf_o   (tx_ovf),
    .unr_o   (tx_unr)
  );

  spi_word_fifo #(.W(W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rx_flush_q),
    .push_i  (eng_push_i),
    .wdata_i (eng_wdata_i),
    .pop_i   (sw_pop_i),
    .rdata_o (sw_rdata_o),
    .full_o  (rx_full),
    .empty_o (rx_empty),
    .ovf_o   (rx_ovf),
    .unr_o   (rx_unr)
  );

  // flush request lives exactly one cycle, then the FIFO is reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_flush_q <= 1'b0;
      rx_flush_q <= 1'b0;
    end else begin
      tx_flush_q <= !tx_flush_q && sts_wr_i && sts_wdata_i[STS_TX_FLUSH];
      rx_flush_q <= !rx_flush_q && sts_wr_i && sts_wdata_i[STS_RX_FLUSH];
    end
  end

  assign sticky_set = {tx_ovf, tx_unr, rx_ovf, rx_unr};
  assign sticky_clr = sts_wr_i ? sts_wdata_i[STICKY_LSB +: NUM_STICKY] : '0;

  spi_sticky_w1c #(.N(NUM_STICKY)) u_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (sticky_set),
    .clr_i  (sticky_clr),
    .q_o    (sticky_q)
  );

  always_comb begin
    sts_rdata_o                                   = '0;
    sts_rdata_o[STS_RX_EMPTY]                     = rx_empty;
    sts_rdata_o[STS_RX_FULL]                      = rx_full;
    sts_rdata_o[STS_TX_EMPTY]                     = tx_empty;
    sts_rdata_o[STS_TX_FULL]                      = tx_full;
    sts_rdata_o[STICKY_LSB +: NUM_STICKY]         = sticky_q;
    sts_rdata_o[STS_ERR]                          = |sticky_q;
    sts_rdata_o[STS_TX_FLUSH]                     = tx_flush_q;
    sts_rdata_o[STS_RX_FLUSH]                     = rx_flush_q;
    sts_rdata_o[STS_FRAME_END]                    = frame_end_i;
    sts_rdata_o[STS_CS_IDLE]                      = cs_idle_i;
  end

  // R6
  err_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sticky_set) |=> sts_rdata_o[STS_ERR]);

  // R8
  flush_self_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush_q |=> (!rx_flush_q && sts_rdata_o[STS_RX_EMPTY]));

  // R8
  flush_keeps_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_flush_q && !sts_wr_i && !(|sticky_set)) |=> $stable(sticky_q));

  // R9
  live_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr_i && !sw_push_i && !sw_pop_i && !eng_push_i && !eng_pop_i
     && !tx_flush_q && !rx_flush_q) |=> $stable(sts_rdata_o[3:0]));
endmodule

// File: tb/spi_fifo_pair_test.sv
module spi_fifo_pair_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sw_push_i = 0, sw_pop_i = 0, sts_wr_i = 0;
  logic        eng_pop_i = 0, eng_push_i = 0;
  logic        frame_end_i = 0, cs_idle_i = 0;
  logic [31:0] sw_wdata_i = 0, sts_wdata_i = 0, eng_wdata_i = 0;
  logic [31:0] sw_rdata_o, sts_rdata_o, eng_rdata_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10ns clk = ~clk;

  spi_fifo_pair uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .sw_push_i(sw_push_i), .sw_wdata_i(sw_wdata_i),
    .sw_pop_i(sw_pop_i), .sw_rdata_o(sw_rdata_o),
    .sts_wr_i(sts_wr_i), .sts_wdata_i(sts_wdata_i), .sts_rdata_o(sts_rdata_o),
    .eng_pop_i(eng_pop_i), .eng_rdata_o(eng_rdata_o),
    .eng_push_i(eng_push_i), .eng_wdata_i(eng_wdata_i),
    .frame_end_i(frame_end_i), .cs_idle_i(cs_idle_i)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic sw_push(logic [31:0] d);
    @(negedge clk); sw_push_i = 1; sw_wdata_i = d;
    @(negedge clk); sw_push_i = 0;
  endtask

  task automatic eng_push(logic [31:0] d);
    @(negedge clk); eng_push_i = 1; eng_wdata_i = d;
    @(negedge clk); eng_push_i = 0;
  endtask

  task automatic sw_pop(output logic [31:0] d);
    @(negedge clk); d = sw_rdata_o; sw_pop_i = 1;
    @(negedge clk); sw_pop_i = 0;
  endtask

  task automatic eng_pop(output logic [31:0] d);
    @(negedge clk); d = eng_rdata_o; eng_pop_i = 1;
    @(negedge clk); eng_pop_i = 0;
  endtask

  task automatic sts_write(logic [31:0] d);
    @(negedge clk); sts_wr_i = 1; sts_wdata_i = d;
    @(negedge clk); sts_wr_i = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 reset status", sts_rdata_o, 32'h0000_0005);
  endtask

  task automatic t_order;
    logic [31:0] d;
    for (int i = 0; i < 8; i++) sw_push(32'hA000_0000 + i);
    check("R2 tx full", sts_rdata_o & 32'hF, 32'h9);
    for (int i = 0; i < 8; i++) begin
      eng_pop(d);
      check("R2 tx order", d, 32'hA000_0000 + i);
    end
    check("R2 tx empty", sts_rdata_o & 32'hF, 32'h5);
    for (int i = 0; i < 8; i++) eng_push(32'hB100_0000 + 3 * i);
    check("R2 rx full", sts_rdata_o & 32'hF, 32'h6);
    for (int i = 0; i < 8; i++) begin
      sw_pop(d);
      check("R2 rx order", d, 32'hB100_0000 + 3 * i);
    end
    check("R2 no flags", sts_rdata_o, 32'h0000_0005);
  endtask

  task automatic t_tx_ovf;
    logic [31:0] d;
    for (int i = 0; i < 8; i++) sw_push(32'hC000_0010 + i);
    sw_push(32'hDEAD_BEEF);
    check("R3 tx ovf flag", sts_rdata_o & 32'h1FF, 32'h189);
    check("R6 err with ovf", {31'b0, sts_rdata_o[8]}, 32'h1);
    // push with simultaneous pop while full: push still dropped
    @(negedge clk); sw_push_i = 1; sw_wdata_i = 32'h5555_5555; eng_pop_i = 1;
    d = eng_rdata_o;
    @(negedge clk); sw_push_i = 0; eng_pop_i = 0;
    check("R3 head word", d, 32'hC000_0010);
    for (int i = 1; i < 8; i++) begin
      eng_pop(d);
      check("R3 contents kept", d, 32'hC000_0010 + i);
    end
    check("R3 no extra word", {31'b0, sts_rdata_o[2]}, 32'h1);
    sts_write(32'h0);
    check("R7 zero write keeps", sts_rdata_o & 32'h1F0, 32'h180);
    sts_write(32'h80);
    check("R7 clear ovf", sts_rdata_o & 32'h1F0, 32'h0);
    check("R6 err cleared", {31'b0, sts_rdata_o[8]}, 32'h0);
  endtask

  task automatic t_underrun;
    logic [31:0] d;
    sw_pop(d);
    check("R4 rx pop empty data", d, 32'h0);
    check("R4 rx unr flag", sts_rdata_o & 32'h1F0, 32'h110);
    eng_push(32'h1234_5678);
    sw_pop(d);
    check("R4 no pointer slip", d, 32'h1234_5678);
    eng_pop(d);
    check("R5 tx pop empty data", d, 32'h0);
    check("R5 tx unr flag", sts_rdata_o & 32'h1F0, 32'h150);
    for (int i = 0; i < 9; i++) eng_push(32'h7700_0000 + i);
    check("R5 rx ovf flag", sts_rdata_o & 32'h1F0, 32'h170);
    sts_write(32'h20);
    check("R7 single clear", sts_rdata_o & 32'h1F0, 32'h150);
    d = sts_rdata_o;
    sts_write(d);
    check("R7 write back clears", sts_rdata_o & 32'h1F0, 32'h0);
    for (int i = 0; i < 8; i++) begin
      sw_pop(d);
      check("R5 rx kept", d, 32'h7700_0000 + i);
    end
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    @(negedge clk); sw_pop_i = 1; sts_wr_i = 1; sts_wdata_i = 32'h10;
    d = sw_rdata_o;
    @(negedge clk); sw_pop_i = 0; sts_wr_i = 0;
    check("R7 set beats clear", sts_rdata_o & 32'h1F0, 32'h110);
    sts_write(32'h10);
    check("R7 cleared after", sts_rdata_o & 32'h1F0, 32'h0);
  endtask

  task automatic t_flush;
    logic [31:0] d;
    sw_pop(d);
    for (int i = 0; i < 3; i++) sw_push(32'hF0 + i);
    for (int i = 0; i < 2; i++) eng_push(32'hE0 + i);
    @(negedge clk); sts_wr_i = 1; sts_wdata_i = 32'h0000_C000;
    @(negedge clk); sts_wr_i = 0;
    check("R8 flush bits pending", sts_rdata_o & 32'hC00F, 32'hC000);
    @(negedge clk);
    check("R8 flush done", sts_rdata_o & 32'hC00F, 32'h0005);
    check("R8 flags kept", sts_rdata_o & 32'h1F0, 32'h110);
    sw_push(32'h0000_ABCD);
    eng_pop(d);
    check("R8 usable after flush", d, 32'h0000_ABCD);
    sts_write(32'h10);
  endtask

  task automatic t_live;
    sw_push(32'h1);
    sts_write(32'h0000_000F);
    check("R9 live bits", sts_rdata_o & 32'hF, 32'h1);
    sts_write(32'h0);
    check("R9 live bits zero write", sts_rdata_o & 32'hF, 32'h1);
    sts_write(32'h0000_4000);
    @(negedge clk);
    frame_end_i = 1;
    #1 check("R10 frame end", sts_rdata_o, 32'h4000_0005);
    frame_end_i = 0; cs_idle_i = 1;
    #1 check("R10 cs idle", sts_rdata_o, 32'h8000_0005);
    cs_idle_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_order();
    t_tx_ovf();
    t_underrun();
    t_set_wins();
    t_flush();
    t_live();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule